// File: doc/BRIEF.md
# Exclusive Access Monitor

This block watches the exclusive-access traffic of several requesters that share one memory. A requester reserves a word with a reserve request and later tries to commit a new value with a conditional store. The block keeps, for every requester, a local reservation with its word address. For addresses in shared regions it also keeps a global reservation, which is dropped when another requester writes that word. A conditional store reaches the memory write port only when the reservations it depends on are still valid. Every conditional store gets a one-bit status back: 0 means written, 1 means no write was made and the sequence must be retried.

Software builds atomic read-modify-write loops and semaphores on top of this: reserve, compute, conditionally store, and retry on status 1. Reads travel the normal memory path and are not handled here; the block only records the reservation. It has a single memory write port. When several conditional stores qualify in the same cycle, the lowest-indexed requester wins and the others report failure.

Top module: `excl_monitor`

## Requirements
- R1: Reset clears every local and global reservation and holds `mem_we`, `st_done` and `st_fail` at 0. A conditional store issued right after reset fails.
- R2: A reserve request (`req_op` code 2'b01) sets the requester's local reservation at its word address. When `req_shared` is 1 it also sets the requester's global reservation at that word.
- R3: A conditional store (`req_op` code 2'b10) that succeeds drives `mem_we`=1 for one cycle, one cycle after the request. In that cycle `mem_addr` is the word-aligned address and `mem_wdata` is the store data. The requester sees `st_done`=1 and `st_fail`=0 in the same cycle.
- R4: A conditional store that fails reports `st_done`=1 and `st_fail`=1 one cycle after the request, with no memory write.
- R5: A conditional store succeeds only if its requester holds a local reservation for the same word.
- R6: Every conditional store clears its requester's local and global reservations, whether it succeeds or fails.
- R7: A clear request (`req_op` code 2'b11) clears the requester's local reservation and causes no memory write. A later conditional store from that requester fails.
- R8: A successful write to a word clears the global reservation of every other requester that holds that word, unless that requester reserves in the same cycle.
- R9: Addresses are compared as 4-byte words, so the two lowest address bits are ignored.
- R10: When several conditional stores qualify in one cycle, only the lowest-indexed one writes. The others report status 1, whatever their addresses.
- R11: For a conditional store with `req_shared`=0, the global reservation is not checked, so the local reservation alone decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 2*NREQ | Per-requester operation: 00 none, 01 reserve, 10 conditional store, 11 clear |
| req_addr | input | NREQ*AW | Per-requester byte address |
| req_shared | input | NREQ | Per-requester shared-region flag |
| req_wdata | input | NREQ*DW | Per-requester store data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Word-aligned memory write address |
| mem_wdata | output | DW | Memory write data |
| st_done | output | NREQ | Conditional store status valid, per requester |
| st_fail | output | NREQ | Conditional store status: 1 failed, 0 written |

## Verification
The assertions assume that each requester presents one well-formed operation per cycle. They also assume that the shared flag is a fixed property of the word address, so a reserve and the later store to the same word carry the same flag. The random stimulus derives the shared flag from address bit 8 and draws addresses from a small pool of words with random low bits. This makes collisions, snoop clears and same-cycle contention frequent. Directed sequences cover the fixed-priority and non-shared cases explicitly.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int NREQ = 3,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int GRAN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NREQ-1:0] req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ-1:0]   req_shared,
  input  logic [NREQ*DW-1:0] req_wdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [NREQ-1:0]   st_done,
  output logic [NREQ-1:0]   st_fail
);
  localparam int WW = AW - GRAN;
  localparam logic [1:0] OP_RSV = 2'b01;
  localparam logic [1:0] OP_STC = 2'b10;
  localparam logic [1:0] OP_CLR = 2'b11;

  logic [NREQ-1:0] lv, gv;
  logic [WW-1:0]   la [NREQ];
  logic [WW-1:0]   ga [NREQ];

  logic [WW-1:0]   wa [NREQ];
  logic [NREQ-1:0] is_rsv, is_stc, is_clr, ok, win, snoop;
  logic [WW-1:0]   wr_wa;
  logic [DW-1:0]   wr_data;

  for (genvar i = 0; i < NREQ; i++) begin : g_dec
    assign wa[i]     = req_addr[i*AW+GRAN +: WW];
    assign is_rsv[i] = req_op[2*i +: 2] == OP_RSV;
    assign is_stc[i] = req_op[2*i +: 2] == OP_STC;
    assign is_clr[i] = req_op[2*i +: 2] == OP_CLR;
    assign ok[i]     = is_stc[i] && lv[i] && la[i] == wa[i] &&
                       (!req_shared[i] || (gv[i] && ga[i] == wa[i]));
    assign snoop[i]  = (|win) && gv[i] && ga[i] == wr_wa;
  end

  assign win = ok & (~ok + 1'b1);

  always_comb begin
    wr_wa   = '0;
    wr_data = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (win[i]) begin
        wr_wa   = wa[i];
        wr_data = req_wdata[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      st_done   <= '0;
      st_fail   <= '0;
      lv        <= '0;
      gv        <= '0;
      for (int i = 0; i < NREQ; i++) begin
        la[i] <= '0;
        ga[i] <= '0;
      end
    end else begin
      mem_we    <= |win;
      mem_addr  <= {wr_wa, {GRAN{1'b0}}};
      mem_wdata <= wr_data;
      st_done   <= is_stc;
      st_fail   <= is_stc & ~win;
      for (int i = 0; i < NREQ; i++) begin
        if (is_stc[i] || is_clr[i]) lv[i] <= 1'b0;
        else if (is_rsv[i]) begin
          lv[i] <= 1'b1;
          la[i] <= wa[i];
        end
        if (is_stc[i]) gv[i] <= 1'b0;
        else if (is_rsv[i]) begin
          gv[i] <= req_shared[i];
          ga[i] <= wa[i];
        end else if (snoop[i]) gv[i] <= 1'b0;
      end
    end
  end
endmodule

module excl_monitor_chk #(
  parameter int NREQ = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NREQ-1:0] req_op,
  input logic              mem_we,
  input logic [NREQ-1:0]   st_done,
  input logic [NREQ-1:0]   st_fail,
  input logic [NREQ-1:0]   lv,
  input logic [NREQ-1:0]   gv
);
  // R3
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_done & ~st_fail) == (mem_we ? 1 : 0));

  // R10
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_done & ~st_fail));

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    // R4
    stc_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_op[2*i +: 2] == 2'b10 |=> st_done[i]);

    // R5
    succ_needs_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_done[i] && !st_fail[i]) |-> $past(lv[i]));

    // R6
    stc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_op[2*i +: 2] == 2'b10 |=> (!lv[i] && !gv[i]));

    // R7
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_op[2*i +: 2] == 2'b11 |=> !lv[i]);
  end
endmodule

bind excl_monitor excl_monitor_chk #(.NREQ(NREQ)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_op(req_op), .mem_we(mem_we),
  .st_done(st_done), .st_fail(st_fail), .lv(lv), .gv(gv)
);

// File: tb/excl_monitor_tb.sv
`timescale 1ns/1ps
module excl_monitor_tb_top;
  localparam int NREQ = 3;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [1:0] NOP = 2'b00, RSV = 2'b01, STC = 2'b10, CLR = 2'b11;
  localparam logic [AW-1:0] AMASK = ~(AW'(3));

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [1:0]    b_op   [NREQ];
  logic [AW-1:0] b_addr [NREQ];
  logic          b_sh   [NREQ];
  logic [DW-1:0] b_d    [NREQ];

  logic [2*NREQ-1:0]  req_op;
  logic [NREQ*AW-1:0] req_addr;
  logic [NREQ-1:0]    req_shared;
  logic [NREQ*DW-1:0] req_wdata;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [NREQ-1:0] st_done, st_fail;

  always_comb
    for (int i = 0; i < NREQ; i++) begin
      req_op[2*i +: 2]     = b_op[i];
      req_addr[i*AW +: AW] = b_addr[i];
      req_shared[i]        = b_sh[i];
      req_wdata[i*DW +: DW] = b_d[i];
    end

  excl_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW), .GRAN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
    .req_shared(req_shared), .req_wdata(req_wdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .st_done(st_done), .st_fail(st_fail));

  int nchk = 0, nfail = 0;
  logic          m_lv [NREQ];
  logic          m_gv [NREQ];
  logic [AW-1:0] m_la [NREQ];
  logic [AW-1:0] m_ga [NREQ];

  task automatic finish_run();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic idle();
    for (int i = 0; i < NREQ; i++) begin
      b_op[i] = NOP; b_addr[i] = '0; b_sh[i] = 0; b_d[i] = '0;
    end
  endtask

  task automatic put(input int i, input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    b_op[i] = op; b_addr[i] = a; b_sh[i] = a[8]; b_d[i] = d;
  endtask

  task automatic cyc(input string tag);
    logic [NREQ-1:0] ok, win, e_done, e_fail;
    logic e_we, found;
    logic [AW-1:0] e_addr, a;
    logic [DW-1:0] e_data;
    e_we = 0; found = 0; e_addr = '0; e_data = '0;
    for (int i = 0; i < NREQ; i++) begin
      a = b_addr[i] & AMASK;
      ok[i] = b_op[i] == STC && m_lv[i] && m_la[i] == a &&
              (!b_sh[i] || (m_gv[i] && m_ga[i] == a));
      win[i] = ok[i] && !found;
      if (win[i]) begin e_we = 1; e_addr = a; e_data = b_d[i]; end
      found = found | ok[i];
      e_done[i] = b_op[i] == STC;
      e_fail[i] = e_done[i] && !win[i];
    end
    for (int i = 0; i < NREQ; i++) begin
      a = b_addr[i] & AMASK;
      if (b_op[i] == STC || b_op[i] == CLR) m_lv[i] = 0;
      else if (b_op[i] == RSV) begin m_lv[i] = 1; m_la[i] = a; end
      if (b_op[i] == STC) m_gv[i] = 0;
      else if (b_op[i] == RSV) begin m_gv[i] = b_sh[i]; m_ga[i] = a; end
      else if (e_we && m_gv[i] && m_ga[i] == e_addr) m_gv[i] = 0;
    end
    @(posedge clk); #1;
    nchk++;
    if (mem_we !== e_we || (e_we && (mem_addr !== e_addr || mem_wdata !== e_data)) ||
        st_done !== e_done || st_fail !== e_fail) begin
      nfail++;
      $display("FAIL %s: we=%b addr=%h data=%h done=%b fail=%b, expected we=%b addr=%h data=%h done=%b fail=%b",
               tag, mem_we, mem_addr, mem_wdata, st_done, st_fail, e_we, e_addr, e_data, e_done, e_fail);
    end
    idle();
  endtask

  task automatic expect_fail(input string tag, input int i, input logic exp);
    nchk++;
    if (st_fail[i] !== exp || st_done[i] !== 1'b1) begin
      nfail++;
      $display("FAIL %s: requester %0d done=%b status=%b, expected done=1 status=%b", tag, i, st_done[i], st_fail[i], exp);
    end
  endtask

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] pool [4];
    pool[0] = 32'h100; pool[1] = 32'h104; pool[2] = 32'h200; pool[3] = 32'h204;
    for (int i = 0; i < NREQ; i++) begin m_lv[i] = 0; m_gv[i] = 0; m_la[i] = '0; m_ga[i] = '0; end
    idle();
    void'($urandom(32'h5eed));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    nchk++;
    if (mem_we !== 0 || st_done !== 0 || st_fail !== 0) begin
      nfail++;
      $display("FAIL R1: we=%b done=%b fail=%b, expected all 0", mem_we, st_done, st_fail);
    end
    put(0, STC, 32'h100, 32'h11); cyc("R1 store after reset"); expect_fail("R1", 0, 1);
    put(0, RSV, 32'h100, 0);      cyc("R2 reserve shared");
    put(0, STC, 32'h100, 32'hAA); cyc("R3 store success"); expect_fail("R3", 0, 0);
    put(0, STC, 32'h100, 32'hAB); cyc("R6 second store");  expect_fail("R6", 0, 1);
    put(1, RSV, 32'h203, 0);      cyc("R9 reserve offset");
    put(1, STC, 32'h200, 32'h22); cyc("R9 store aligned"); expect_fail("R9", 1, 0);
    put(2, RSV, 32'h204, 0);      cyc("R5 reserve");
    put(2, STC, 32'h200, 32'h33); cyc("R5 other word");    expect_fail("R5", 2, 1);
    put(0, RSV, 32'h204, 0);      cyc("R7 reserve");
    put(0, CLR, 32'h204, 0);      cyc("R7 clear");
    put(0, STC, 32'h204, 32'h44); cyc("R7 store after clear"); expect_fail("R7", 0, 1);
    put(0, RSV, 32'h100, 0); put(1, RSV, 32'h101, 0); cyc("R8 both reserve");
    put(1, STC, 32'h100, 32'h55); cyc("R8 winner write");  expect_fail("R8", 1, 0);
    put(0, STC, 32'h100, 32'h66); cyc("R8 snooped store"); expect_fail("R8", 0, 1);
    put(0, RSV, 32'h200, 0); put(1, RSV, 32'h200, 0); cyc("R11 reserve");
    put(1, STC, 32'h200, 32'h77); cyc("R11 first write");
    put(0, STC, 32'h200, 32'h88); cyc("R11 local only"); expect_fail("R11", 0, 0);
    put(0, RSV, 32'h100, 0); put(1, RSV, 32'h100, 0); put(2, RSV, 32'h100, 0); cyc("R10 reserve");
    put(1, STC, 32'h100, 32'h91); put(2, STC, 32'h100, 32'h92); cyc("R10 contention");
    expect_fail("R10", 1, 0); expect_fail("R10", 2, 1);
    put(0, RSV, 32'h200, 0); put(2, RSV, 32'h204, 0); cyc("R10 reserve apart");
    put(0, STC, 32'h200, 32'hA0); put(2, STC, 32'h204, 32'hA2); cyc("R10 distinct words");
    expect_fail("R10", 0, 0); expect_fail("R10", 2, 1);
    put(0, STC, 32'h100, 0); put(1, STC, 32'h100, 0); put(2, STC, 32'h100, 0); cyc("R6 drain");
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NREQ; i++) begin
        logic [AW-1:0] a;
        logic [1:0] op;
        int r;
        r = $urandom_range(0, 9);
        op = (r < 2) ? NOP : (r < 5) ? RSV : (r < 9) ? STC : CLR;
        a = pool[$urandom_range(0, 3)] | AW'($urandom_range(0, 3));
        put(i, op, a, $urandom());
      end
      cyc("R2-R11 random");
    end
    finish_run();
  end
endmodule